// File: doc/BRIEF.md
# Pretrigger Ring-Buffer Capture Controller

This block runs a sample-capture memory as a circular buffer whose length is set at run time. A start command records the configuration, and from then on every sample-enable pulse writes one sample to the next address in the ring. When the address reaches the last slot of the region it wraps to zero. Trigger detection stays disarmed until the programmed number of pretrigger samples has been stored. The first qualified trigger after arming marks the trigger sample. A programmed number of further samples is then stored, and recording stops.

When recording ends, the block raises a done flag. It reports the address of the trigger sample and the address of the oldest valid sample, so that a reader can unroll the ring in time order. A stop command aborts recording from any state. A configuration that cannot fit in the ring is rejected with an error flag. The sample source, the trigger detector and the memory are outside the block. The memory is reached through a plain write port: enable, address and data.

Top module: `ring_capture_ctrl`

## Requirements
- R1: After an accepted start the first sample is written at address 0. Each further sample goes to the next address, and after address depth-1 the next address is 0.
- R2: While recording, every cycle with `smp_valid` high produces exactly one write, with `mem_wdata` equal to `smp_data` in the same cycle. No write occurs while the block is idle or done.
- R3: Until `cfg_pre` samples have been written since start, `armed` is 0 and `trig_in` has no effect. `armed` rises once that many samples have been written. With `cfg_pre` = 0 it is high from the first recording cycle.
- R4: A trigger is accepted in a cycle where `armed`, `trig_in` and `smp_valid` are all high. That sample is the trigger sample, and it is itself written. On the next clock edge `triggered` is 1, `armed` is 0 and `trig_addr` holds the trigger sample's address.
- R5: After the trigger sample, exactly `cfg_post` further samples are written. After the edge of the last of them, `done` is 1 and `busy` is 0. With `cfg_post` = 0, done follows the trigger sample.
- R6: After a trigger has been accepted, further trigger pulses do not change `triggered` or `trig_addr` until the next start.
- R7: A start is rejected when depth is 0, when depth exceeds 2^ADDR_W, or when `cfg_pre` + `cfg_post` exceeds depth. A rejected start sets `cfg_err`, leaves the block idle and causes no writes. The next accepted start clears `cfg_err`.
- R8: `stop` suppresses any write in its own cycle. After the next edge the block is idle with `done` and `triggered` at 0, whatever state it was in. `stop` takes priority over `start`.
- R9: While `done` is 1, `oldest_addr` is the address that the next write would have used if the ring has wrapped at least once, and 0 otherwise.
- R10: A start pulse while recording is ignored. The address sequence and the counts carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; latches the configuration |
| stop | input | 1 | Abort pulse; highest priority |
| cfg_depth | input | ADDR_W+1 | Ring length in samples |
| cfg_pre | input | ADDR_W+1 | Samples to store before arming |
| cfg_post | input | ADDR_W+1 | Samples to store after the trigger sample |
| smp_valid | input | 1 | Sample-enable pulse |
| smp_data | input | DATA_W | Sample value |
| trig_in | input | 1 | Trigger event from the detector |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | Recording in progress |
| armed | output | 1 | Trigger detection enabled |
| triggered | output | 1 | A trigger has been accepted |
| done | output | 1 | Recording complete |
| cfg_err | output | 1 | Last start was rejected |
| trig_addr | output | ADDR_W | Address of the trigger sample |
| oldest_addr | output | ADDR_W | Address of the oldest valid sample when done |

## Verification
The write port is combinational. Each write's enable, address and data are therefore checked one nanosecond after the inputs change on the falling edge, before the rising edge that consumes the sample. The `armed`, `triggered`, `done`, `busy`, `cfg_err` and address reports are registered, so they change on the rising edge that takes in the qualifying sample, start or stop. The bench reads them on the next falling edge. Every scenario task keeps to this one-edge rule for status and the same-cycle rule for writes, and the expected values come from counting samples in the order they were sent.

// File: rtl/rcap_pkg.sv
package rcap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REC  = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } rcap_state_t;
endpackage

// File: rtl/rcap_cfg_chk.sv
module rcap_cfg_chk #(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W:0] depth,
   input  logic [ADDR_W:0] pre,
   input  logic [ADDR_W:0] post,
   output logic            ok
);
   localparam int CNT_W = ADDR_W + 1;
   localparam logic [CNT_W:0] MAX_DEPTH = (CNT_W+1)'(1) << ADDR_W;

   logic [CNT_W:0] span;
   logic [CNT_W:0] depth_x;

   always_comb begin
      span    = {1'b0, pre} + {1'b0, post};
      depth_x = {1'b0, depth};
      ok      = (depth != '0) && (depth_x <= MAX_DEPTH) && (span <= depth_x);
   end
endmodule

// File: rtl/rcap_addr_gen.sv
module rcap_addr_gen #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [ADDR_W:0]   last,
   output logic [ADDR_W-1:0] ptr,
   output logic              wrapped
);
   logic at_end;
   assign at_end = ({1'b0, ptr} == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         wrapped <= 1'b0;
      end else if (clr) begin
         ptr     <= '0;
         wrapped <= 1'b0;
      end else if (adv) begin
         if (at_end) begin
            ptr     <= '0;
            wrapped <= 1'b1;
         end else begin
            ptr <= ptr + 1'b1;
         end
      end
   end

   // R1
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && at_end) |=> (ptr == '0 && wrapped));
endmodule

// File: rtl/rcap_fill_ctr.sv
module rcap_fill_ctr #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic             reached
);
   logic [CNT_W-1:0] cnt;

   assign reached = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && !reached)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ring_capture_ctrl.sv
module ring_capture_ctrl
   import rcap_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [ADDR_W:0]   cfg_depth,
   input  logic [ADDR_W:0]   cfg_pre,
   input  logic [ADDR_W:0]   cfg_post,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              trig_in,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              armed,
   output logic              triggered,
   output logic              done,
   output logic              cfg_err,
   output logic [ADDR_W-1:0] trig_addr,
   output logic [ADDR_W-1:0] oldest_addr
);
   localparam int CNT_W = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr_w
      $error("ring_capture_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("ring_capture_ctrl: DATA_W must be positive");
   end

   rcap_state_t      state_q;
   logic [CNT_W-1:0] depth_q, pre_q, post_q, post_left_q;
   logic [CNT_W-1:0] last_idx;
   logic             trig_q, done_q, err_q;
   logic [ADDR_W-1:0] trig_addr_q;
   logic             cfg_ok, pre_hit, wrapped, accept, go;
   logic [ADDR_W-1:0] ptr;

   rcap_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
      .depth (cfg_depth),
      .pre   (cfg_pre),
      .post  (cfg_post),
      .ok    (cfg_ok)
   );

   assign busy     = (state_q == ST_REC) || (state_q == ST_POST);
   assign go       = start && !stop && !busy && cfg_ok;
   assign mem_we   = busy && smp_valid && !stop;
   assign mem_addr = ptr;
   assign mem_wdata = smp_data;
   assign last_idx = depth_q - 1'b1;

   rcap_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go),
      .adv     (mem_we),
      .last    (last_idx),
      .ptr     (ptr),
      .wrapped (wrapped)
   );

   rcap_fill_ctr #(.CNT_W(CNT_W)) u_fill (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go),
      .inc     (mem_we),
      .limit   (pre_q),
      .reached (pre_hit)
   );

   assign armed  = (state_q == ST_REC) && pre_hit;
   assign accept = armed && trig_in && mem_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         depth_q     <= CNT_W'(1);
         pre_q       <= '0;
         post_q      <= '0;
         post_left_q <= '0;
         trig_q      <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         trig_addr_q <= '0;
      end else if (stop) begin
         state_q <= ST_IDLE;
         trig_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  if (cfg_ok) begin
                     state_q <= ST_REC;
                     depth_q <= cfg_depth;
                     pre_q   <= cfg_pre;
                     post_q  <= cfg_post;
                     trig_q  <= 1'b0;
                     done_q  <= 1'b0;
                     err_q   <= 1'b0;
                  end else begin
                     state_q <= ST_IDLE;
                     trig_q  <= 1'b0;
                     done_q  <= 1'b0;
                     err_q   <= 1'b1;
                  end
               end
            end
            ST_REC: begin
               if (accept) begin
                  trig_q      <= 1'b1;
                  trig_addr_q <= ptr;
                  post_left_q <= post_q;
                  if (post_q == '0) begin
                     state_q <= ST_DONE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_POST;
                  end
               end
            end
            ST_POST: begin
               if (mem_we) begin
                  post_left_q <= post_left_q - 1'b1;
                  if (post_left_q == CNT_W'(1)) begin
                     state_q <= ST_DONE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign triggered   = trig_q;
   assign done        = done_q;
   assign cfg_err     = err_q;
   assign trig_addr   = trig_addr_q;
   assign oldest_addr = (done_q && wrapped) ? ptr : '0;

   // R1
   addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, mem_addr} <= last_idx));
   // R3
   no_early_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_REC) && !armed && !stop) |=> !triggered);
   // R5
   no_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_we);
   // R6
   trig_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && triggered && !stop) |=> $stable(trig_addr));
   // R7
   bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop && !busy && !cfg_ok) |=> (cfg_err && !busy));
   // R8
   stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!busy && !done && !triggered));
endmodule

// File: tb/ring_capture_ctrl_test.sv
module ring_capture_ctrl_test;
   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, stop = 1'b0;
   logic [AW:0]   cfg_depth = '0, cfg_pre = '0, cfg_post = '0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          trig_in = 1'b0;
   logic          mem_we, busy, armed, triggered, done, cfg_err;
   logic [AW-1:0] mem_addr, trig_addr, oldest_addr;
   logic [DW-1:0] mem_wdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   ring_capture_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .cfg_depth(cfg_depth), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
      .smp_valid(smp_valid), .smp_data(smp_data), .trig_in(trig_in),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .armed(armed), .triggered(triggered), .done(done),
      .cfg_err(cfg_err), .trig_addr(trig_addr), .oldest_addr(oldest_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_start(input int d, input int p, input int q);
      @(negedge clk);
      cfg_depth = (AW+1)'(d); cfg_pre = (AW+1)'(p); cfg_post = (AW+1)'(q);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // one sample; the write is checked in its own cycle
   task automatic samp(input int dat, input bit trg, input int exp_addr, input string req);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = DW'(dat); trig_in = trg;
      #1;
      chk(mem_we == 1'b1, req, int'(mem_we), 1);
      chk(int'(mem_addr) == exp_addr, req, int'(mem_addr), exp_addr);
      chk(int'(mem_wdata) == (dat & 16'hFFFF), "R2", int'(mem_wdata), dat & 16'hFFFF);
      @(negedge clk);
      smp_valid = 1'b0; trig_in = 1'b0;
   endtask

   task automatic no_write(input string req);
      @(negedge clk);
      smp_valid = 1'b1; trig_in = 1'b1;
      #1;
      chk(mem_we == 1'b0, req, int'(mem_we), 0);
      @(negedge clk);
      smp_valid = 1'b0; trig_in = 1'b0;
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R2 reset busy", int'(busy), 0);
      chk(done == 1'b0, "R5 reset done", int'(done), 0);
      chk(armed == 1'b0, "R3 reset armed", int'(armed), 0);
      chk(cfg_err == 1'b0, "R7 reset err", int'(cfg_err), 0);
      no_write("R2 idle");
   endtask

   task automatic t_bad_cfg();
      do_start(0, 0, 0);
      chk(cfg_err == 1'b1, "R7 depth0", int'(cfg_err), 1);
      chk(busy == 1'b0, "R7 depth0 idle", int'(busy), 0);
      no_write("R7 no write");
      do_start(4, 3, 2);
      chk(cfg_err == 1'b1, "R7 pre+post", int'(cfg_err), 1);
      do_start((1 << AW) + 1, 0, 0);
      chk(cfg_err == 1'b1, "R7 too deep", int'(cfg_err), 1);
      chk(busy == 1'b0, "R7 too deep idle", int'(busy), 0);
   endtask

   task automatic t_basic();
      do_start(8, 3, 2);
      chk(cfg_err == 1'b0, "R7 clear", int'(cfg_err), 0);
      chk(busy == 1'b1, "R1 busy", int'(busy), 1);
      chk(armed == 1'b0, "R3 not armed", int'(armed), 0);
      samp(16'h100, 1'b1, 0, "R1");
      samp(16'h101, 1'b1, 1, "R1");
      chk(armed == 1'b0, "R3 still disarmed", int'(armed), 0);
      samp(16'h102, 1'b1, 2, "R1");
      chk(triggered == 1'b0, "R3 early trig ignored", int'(triggered), 0);
      chk(armed == 1'b1, "R3 armed", int'(armed), 1);
      samp(16'h103, 1'b0, 3, "R2");
      samp(16'h104, 1'b1, 4, "R4");
      chk(triggered == 1'b1, "R4 triggered", int'(triggered), 1);
      chk(armed == 1'b0, "R4 disarm", int'(armed), 0);
      chk(int'(trig_addr) == 4, "R4 trig addr", int'(trig_addr), 4);
      samp(16'h105, 1'b0, 5, "R5");
      chk(done == 1'b0, "R5 not yet done", int'(done), 0);
      samp(16'h106, 1'b0, 6, "R5");
      chk(done == 1'b1, "R5 done", int'(done), 1);
      chk(busy == 1'b0, "R5 idle", int'(busy), 0);
      chk(int'(oldest_addr) == 0, "R9 unwrapped", int'(oldest_addr), 0);
      no_write("R5 no write after done");
   endtask

   task automatic t_wrap();
      do_start(5, 2, 2);
      for (int i = 0; i < 11; i++) begin
         samp(i + 16'h200, 1'b0, i % 5, "R1 wrap");
         if (i == 6) begin
            do_start(8, 0, 0); // R10: ignored while recording
            chk(busy == 1'b1, "R10 start ignored", int'(busy), 1);
         end
      end
      samp(16'h20B, 1'b1, 1, "R4");
      chk(int'(trig_addr) == 1, "R4 trig addr wrap", int'(trig_addr), 1);
      samp(16'h20C, 1'b1, 2, "R6");
      chk(int'(trig_addr) == 1, "R6 retrigger ignored", int'(trig_addr), 1);
      samp(16'h20D, 1'b0, 3, "R5");
      chk(done == 1'b1, "R5 done wrap", int'(done), 1);
      chk(int'(oldest_addr) == 4, "R9 oldest", int'(oldest_addr), 4);
   endtask

   task automatic t_stop();
      do_start(8, 0, 4);
      samp(16'h300, 1'b1, 0, "R4");
      samp(16'h301, 1'b0, 1, "R5");
      @(negedge clk);
      stop = 1'b1; smp_valid = 1'b1;
      #1;
      chk(mem_we == 1'b0, "R8 stop blocks write", int'(mem_we), 0);
      @(negedge clk);
      stop = 1'b0; smp_valid = 1'b0;
      chk(busy == 1'b0, "R8 idle", int'(busy), 0);
      chk(done == 1'b0, "R8 no done", int'(done), 0);
      chk(triggered == 1'b0, "R8 trig cleared", int'(triggered), 0);
      no_write("R8 no write after stop");
   endtask

   task automatic t_zero_post();
      do_start(4, 0, 0);
      chk(armed == 1'b1, "R3 pre0 armed", int'(armed), 1);
      samp(16'h400, 1'b1, 0, "R4");
      chk(done == 1'b1, "R5 post0 done", int'(done), 1);
      chk(int'(trig_addr) == 0, "R4 post0 addr", int'(trig_addr), 0);
      chk(int'(oldest_addr) == 0, "R9 post0", int'(oldest_addr), 0);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_cfg();
      t_basic();
      t_wrap();
      t_stop();
      t_zero_post();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule